// File: doc/BRIEF.md
# Write-Once Software Watchdog

This block guards a system against software that stops running. Software must prove it is alive by writing a two-value key sequence to a service port before a countdown runs out. If the countdown expires, the block raises either a reset request to the reset sequencer or a non-maskable interrupt to the processor. A control bit chooses which of the two.

The block leaves reset armed, with the longest period, the prescaler on and the reset action selected. Software gets exactly one write to the control register after each reset. That write can turn the watchdog off, shorten its period, drop the prescaler or pick the interrupt action. After it, the register is frozen until the next reset. The countdown only moves on cycles where the external prescaled `tick` input is high.

Top module: `svc_watchdog`

## Requirements
- R1: After reset, `rst_req` and `nmi` are low, and the control state is: enabled, period all ones, prescaler on, action = reset request.
- R2: From reset, with `tick` high every cycle, the first reset request appears after exactly 2^TMO_W × PRESCALE ticks.
- R3: The control word is laid out as follows. Bits [TMO_W-1:0] hold the period P. Bit TMO_W turns the ÷PRESCALE prescaler on. Bit TMO_W+1 picks the action (1 = reset request, 0 = NMI). Bit TMO_W+2 is the enable. An accepted write applies all fields and reloads the countdown, so a timeout follows after (P+1) countdown steps.
- R4: Only the first control write after reset is accepted. Every later write is ignored and does not reload the countdown.
- R5: A service write of 16'h556C followed by a service write of 16'hAA39 reloads the countdown from the current period and restarts the prescaler.
- R6: Any other service value breaks off the sequence. 16'hAA39 without a directly preceding 16'h556C does not service.
- R7: A timeout with the reset action drives `rst_req` high for exactly RST_LEN cycles. The countdown reloads and keeps running.
- R8: A timeout with the NMI action sets `nmi`, which stays high until `nmi_clr`. When a timeout and `nmi_clr` arrive in the same cycle, the set wins. The countdown reloads after the timeout.
- R9: While disabled, the block produces no timeout.
- R10: A countdown step happens on each cycle with `tick` high when the prescaler is off, or on every PRESCALE-th tick when it is on. Cycles with `tick` low do not count.
- R11: A service that completes in the same cycle as the final countdown step prevents that timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | TMO_W+3 | Control word (layout in R3) |
| svc_we | input | 1 | Service write strobe |
| svc_wdata | input | 16 | Service key value |
| tick | input | 1 | Prescaled time tick |
| nmi_clr | input | 1 | Clears a pending NMI |
| rst_req | output | 1 | Reset request pulse |
| nmi | output | 1 | Held non-maskable interrupt |

## Verification
The hardest case to reach is a service that completes on the very cycle the countdown would expire. From the ports this needs exact knowledge of the count. The bench therefore takes its single control write to get a short period with the prescaler off. It waits for a timeout so that it knows the counter has just reloaded, arms the first key on a cycle without a tick, and delivers the second key together with the final tick. The reset-default path, with its long period, is reached with a reduced period width and prescale ratio.

// File: rtl/wdog_pkg.sv
// Shared constants and types for the software watchdog.
// Assumes 16-bit service keys; the two values are fixed by software convention.
package wdog_pkg;
    localparam logic [15:0] KEY_ARM  = 16'h556C;
    localparam logic [15:0] KEY_FIRE = 16'hAA39;

    typedef enum logic {
        ACT_NMI   = 1'b0,
        ACT_RESET = 1'b1
    } wdog_act_e;
endpackage

// File: rtl/wdog_cfg_reg.sv
// Write-once control register. Reset loads the safest setting: enabled,
// maximum period, prescaler on, reset action. The first write is taken and
// locks the register until the next reset. Assumes one write per strobe cycle.
module wdog_cfg_reg
    import wdog_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [TMO_W+2:0]     wdata,
    output logic [TMO_W-1:0]     period,
    output logic                 pre_en,
    output wdog_act_e            act,
    output logic                 en,
    output logic                 locked,
    output logic                 load,
    output logic [TMO_W-1:0]     load_val
);
    localparam int PRE_BIT = TMO_W;
    localparam int ACT_BIT = TMO_W + 1;
    localparam int EN_BIT  = TMO_W + 2;

    // A write is only taken while still unlocked
    assign load     = we && !locked;
    assign load_val = wdata[TMO_W-1:0];

    // Hold the fields; capture them once after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period <= '1;
            pre_en <= 1'b1;
            act    <= ACT_RESET;
            en     <= 1'b1;
            locked <= 1'b0;
        end else if (load) begin
            period <= wdata[TMO_W-1:0];
            pre_en <= wdata[PRE_BIT];
            act    <= wdog_act_e'(wdata[ACT_BIT]);
            en     <= wdata[EN_BIT];
            locked <= 1'b1;
        end
    end
endmodule

// File: rtl/wdog_svc_seq.sv
// Service key detector. The arm key primes it; the fire key right after it
// produces a one-cycle kick. Any other value disarms. Assumes keys arrive on
// svc strobes only.
module wdog_svc_seq
    import wdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [15:0] wdata,
    output logic        kick
);
    logic armed;

    // Kick when the fire key follows the arm key directly
    assign kick = we && armed && (wdata == KEY_FIRE);

    // Track whether the last service write was the arm key
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (we)
            armed <= (wdata == KEY_ARM);
    end
endmodule

// File: rtl/wdog_count.sv
// Prescaler and countdown. A step happens on a tick (every PRESCALE-th tick
// when prescaling). A step at zero is a timeout and reloads the count.
// Priority: control load, then service kick, then stepping.
// Assumes the reset value of the count equals the reset period (all ones).
module wdog_count #(
    parameter int TMO_W    = 16,
    parameter int PRESCALE = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              pre_en,
    input  logic              tick,
    input  logic [TMO_W-1:0]  period,
    input  logic              load,
    input  logic [TMO_W-1:0]  load_val,
    input  logic              kick,
    output logic              expire,
    output logic [TMO_W-1:0]  cnt
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    logic [PRE_W-1:0] pre;
    logic             step;

    // Step when a tick completes a prescale period (or any tick unscaled)
    assign step   = en && tick && (!pre_en || pre == PRE_LAST);
    // Timeout only if nothing reloads in the same cycle
    assign expire = step && (cnt == '0) && !load && !kick;

    // Advance prescaler and countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '1;
            pre <= '0;
        end else if (load) begin
            cnt <= load_val;
            pre <= '0;
        end else if (kick) begin
            cnt <= period;
            pre <= '0;
        end else if (en && tick) begin
            if (pre_en)
                pre <= (pre == PRE_LAST) ? '0 : pre + 1'b1;
            if (step)
                cnt <= (cnt == '0) ? period : cnt - 1'b1;
        end
    end
endmodule

// File: rtl/wdog_alarm.sv
// Timeout action stage. The reset action starts a fixed-length request pulse
// (a new timeout restarts it); the NMI action sets a flag held until cleared.
// Set wins over clear. Assumes RST_LEN >= 1.
module wdog_alarm
    import wdog_pkg::*;
#(
    parameter int RST_LEN = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      expire,
    input  wdog_act_e act,
    input  logic      nmi_clr,
    output logic      rst_req,
    output logic      nmi
);
    localparam int RC_W = $clog2(RST_LEN + 1);

    logic [RC_W-1:0] rst_left;

    assign rst_req = (rst_left != '0);

    // Count down the remaining reset request cycles
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_left <= '0;
        else if (expire && act == ACT_RESET)
            rst_left <= RC_W'(RST_LEN);
        else if (rst_left != '0)
            rst_left <= rst_left - 1'b1;
    end

    // Hold the NMI until software clears it
    always_ff @(posedge clk) begin
        if (!rst_n)
            nmi <= 1'b0;
        else if (expire && act == ACT_NMI)
            nmi <= 1'b1;
        else if (nmi_clr)
            nmi <= 1'b0;
    end
endmodule

// File: rtl/svc_watchdog.sv
// Software watchdog top. Wires the write-once control register, service key
// detector, countdown and action stage. Assumes tick is already prescaled and
// synchronous to clk; reset sequencing is done outside.
module svc_watchdog
    import wdog_pkg::*;
#(
    parameter int TMO_W    = 16,
    parameter int PRESCALE = 2048,
    parameter int RST_LEN  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [TMO_W+2:0] cfg_wdata,
    input  logic             svc_we,
    input  logic [15:0]      svc_wdata,
    input  logic             tick,
    input  logic             nmi_clr,
    output logic             rst_req,
    output logic             nmi
);
    logic [TMO_W-1:0] cfg_period;
    logic             cfg_pre_en;
    wdog_act_e        cfg_act;
    logic             cfg_en;
    logic             cfg_locked;
    logic             cfg_load;
    logic [TMO_W-1:0] cfg_load_val;
    logic             kick;
    logic             expire;
    logic [TMO_W-1:0] cnt;

    wdog_cfg_reg #(.TMO_W(TMO_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .period(cfg_period), .pre_en(cfg_pre_en), .act(cfg_act),
        .en(cfg_en), .locked(cfg_locked), .load(cfg_load),
        .load_val(cfg_load_val)
    );

    wdog_svc_seq u_svc (
        .clk(clk), .rst_n(rst_n), .we(svc_we), .wdata(svc_wdata),
        .kick(kick)
    );

    wdog_count #(.TMO_W(TMO_W), .PRESCALE(PRESCALE)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(cfg_en), .pre_en(cfg_pre_en),
        .tick(tick), .period(cfg_period), .load(cfg_load),
        .load_val(cfg_load_val), .kick(kick), .expire(expire), .cnt(cnt)
    );

    wdog_alarm #(.RST_LEN(RST_LEN)) u_alarm (
        .clk(clk), .rst_n(rst_n), .expire(expire), .act(cfg_act),
        .nmi_clr(nmi_clr), .rst_req(rst_req), .nmi(nmi)
    );
endmodule

// File: rtl/wdog_chk.sv
// Property checker for svc_watchdog, attached by bind. Observes control
// state, the kick strobe and the count alongside the outputs.
module wdog_chk
    import wdog_pkg::*;
#(
    parameter int TMO_W   = 16,
    parameter int RST_LEN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_req,
    input  logic             nmi,
    input  logic             nmi_clr,
    input  logic             en,
    input  logic             pre_en,
    input  wdog_act_e        act,
    input  logic             locked,
    input  logic             load,
    input  logic             kick,
    input  logic [TMO_W-1:0] period,
    input  logic [TMO_W-1:0] cnt
);
    logic [15:0] run;

    // Length of the current reset request run, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)
            run <= '0;
        else if (!rst_req)
            run <= '0;
        else if (run != 16'hFFFF)
            run <= run + 1'b1;
    end

    a_r4_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> ($stable(period) && $stable(en) && $stable(pre_en) && $stable(act) && locked));

    a_r5_kick_reloads: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && !load) |=> (cnt == $past(period)));

    a_r7_pulse_min_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req) |-> (run >= 16'(RST_LEN)));

    a_r8_nmi_held: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi && !nmi_clr) |=> nmi);

    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!$rose(rst_req) && !$rose(nmi)));
endmodule

bind svc_watchdog wdog_chk #(.TMO_W(TMO_W), .RST_LEN(RST_LEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .nmi(nmi), .nmi_clr(nmi_clr),
    .en(cfg_en), .pre_en(cfg_pre_en), .act(cfg_act), .locked(cfg_locked),
    .load(cfg_load), .kick(kick), .period(cfg_period), .cnt(cnt)
);

// File: tb/tb_svc_watchdog.sv
// Bench for svc_watchdog: behavioural model compared every cycle plus
// directed checks per requirement.
module tb_svc_watchdog;
    localparam int CLK_PERIOD = 10;
    localparam int TMO_W      = 6;
    localparam int PRESCALE   = 4;
    localparam int RST_LEN    = 3;
    localparam int CW         = TMO_W + 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [CW-1:0] cfg_wdata = '0;
    logic          svc_we = 1'b0;
    logic [15:0]   svc_wdata = '0;
    logic          tick = 1'b0;
    logic          nmi_clr = 1'b0;
    logic          rst_req;
    logic          nmi;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    svc_watchdog #(.TMO_W(TMO_W), .PRESCALE(PRESCALE), .RST_LEN(RST_LEN)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .svc_we(svc_we), .svc_wdata(svc_wdata), .tick(tick),
        .nmi_clr(nmi_clr), .rst_req(rst_req), .nmi(nmi)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- reference model ----------------
    int m_valid = 0;
    int m_en, m_pre_en, m_act, m_per, m_locked, m_cnt, m_pre, m_armed, m_nmi, m_rst;

    always @(posedge clk) begin
        int expire, kick, step, nxt_armed;
        if (!rst_n) begin
            m_valid = 1; m_en = 1; m_pre_en = 1; m_act = 1;
            m_per = (1 << TMO_W) - 1; m_cnt = m_per; m_locked = 0;
            m_pre = 0; m_armed = 0; m_nmi = 0; m_rst = 0;
        end else if (m_valid != 0) begin
            expire = 0; kick = 0; nxt_armed = m_armed;
            if (svc_we) begin
                if (m_armed != 0 && svc_wdata == 16'hAA39) kick = 1;
                nxt_armed = (svc_wdata == 16'h556C) ? 1 : 0;
            end
            step = (m_en != 0 && tick && (m_pre_en == 0 || m_pre == PRESCALE - 1)) ? 1 : 0;
            if (cfg_we && m_locked == 0) begin
                m_per = int'(cfg_wdata[TMO_W-1:0]);
                m_pre_en = int'(cfg_wdata[TMO_W]);
                m_act = int'(cfg_wdata[TMO_W+1]);
                m_en = int'(cfg_wdata[TMO_W+2]);
                m_locked = 1; m_cnt = m_per; m_pre = 0;
            end else if (kick != 0) begin
                m_cnt = m_per; m_pre = 0;
            end else if (m_en != 0 && tick) begin
                if (m_pre_en != 0) m_pre = (m_pre + 1) % PRESCALE;
                if (step != 0) begin
                    if (m_cnt == 0) begin expire = 1; m_cnt = m_per; end
                    else m_cnt = m_cnt - 1;
                end
            end
            m_armed = nxt_armed;
            if (expire != 0 && m_act == 1) m_rst = RST_LEN;
            else if (m_rst > 0) m_rst = m_rst - 1;
            if (expire != 0 && m_act == 0) m_nmi = 1;
            else if (nmi_clr) m_nmi = 0;
        end
    end

    // Compare outputs against the model on every falling edge
    always @(negedge clk) begin
        if (m_valid != 0 && !finished) begin
            n_checks++;
            if (rst_req !== (m_rst > 0) || nmi !== (m_nmi != 0)) begin
                n_fail++;
                $display("FAIL model R7/R8 outputs: rst_req=%0b nmi=%0b expected %0b %0b",
                         rst_req, nmi, (m_rst > 0), m_nmi);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag, input int act_v, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act_v, exp_v);
        end
    endtask

    task automatic cyc(input bit tk, input bit sw, input logic [15:0] sd,
                       input bit cw, input logic [CW-1:0] cd, input bit clr);
        @(negedge clk);
        tick = tk; svc_we = sw; svc_wdata = sd; cfg_we = cw; cfg_wdata = cd; nmi_clr = clr;
        @(posedge clk);
        #1;
    endtask

    task automatic tk1(); cyc(1, 0, 16'h0, 0, '0, 0); endtask
    task automatic idle(); cyc(0, 0, 16'h0, 0, '0, 0); endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; tick = 0; svc_we = 0; cfg_we = 0; nmi_clr = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
    endtask

    function automatic logic [CW-1:0] mk(input bit en, input bit act, input bit pre, input int per);
        return {en, act, pre, TMO_W'(per)};
    endfunction

    // ---------------- stimulus ----------------
    initial begin
        int rise, fall, hi;
        do_reset();
        // R1: outputs quiet after reset
        chk(rst_req == 0 && nmi == 0, "R1 outputs low after reset", int'(rst_req) + int'(nmi), 0);

        // R2 + R7: default timeout and pulse length
        rise = -1; fall = -1;
        for (int i = 1; i <= 270; i++) begin
            tk1();
            if (rst_req && rise < 0) rise = i;
            if (!rst_req && rise >= 0 && fall < 0) fall = i;
        end
        chk(rise == (1 << TMO_W) * PRESCALE, "R2 default timeout tick count", rise, (1 << TMO_W) * PRESCALE);
        chk(fall - rise == RST_LEN, "R7 reset request length", fall - rise, RST_LEN);

        // R5: correct service postpones the timeout
        do_reset();
        for (int i = 1; i <= 200; i++) tk1();
        cyc(1, 1, 16'h556C, 0, '0, 0);
        cyc(1, 1, 16'hAA39, 0, '0, 0);
        rise = -1;
        for (int i = 203; i <= 470; i++) begin
            tk1();
            if (rst_req && rise < 0) rise = i;
        end
        chk(rise == 202 + (1 << TMO_W) * PRESCALE, "R5 service reloads countdown", rise, 202 + (1 << TMO_W) * PRESCALE);

        // R6: broken and unarmed sequences do not service
        do_reset();
        for (int i = 1; i <= 100; i++) tk1();
        cyc(1, 1, 16'h556C, 0, '0, 0);
        cyc(1, 1, 16'h1234, 0, '0, 0);
        cyc(1, 1, 16'hAA39, 0, '0, 0);
        cyc(1, 1, 16'hAA39, 0, '0, 0);
        rise = -1;
        for (int i = 105; i <= 270; i++) begin
            tk1();
            if (rst_req && rise < 0) rise = i;
        end
        chk(rise == (1 << TMO_W) * PRESCALE, "R6 bad keys ignored", rise, (1 << TMO_W) * PRESCALE);

        // R3 + R8: NMI action, period 5, prescaler off
        do_reset();
        cyc(0, 0, 16'h0, 1, mk(1, 0, 0, 5), 0);
        for (int i = 1; i <= 5; i++) tk1();
        chk(nmi == 0, "R3 no NMI before P+1 steps", int'(nmi), 0);
        tk1();
        chk(nmi == 1, "R3 NMI at step P+1", int'(nmi), 1);
        chk(rst_req == 0, "R3 action NMI gives no reset request", int'(rst_req), 0);
        for (int i = 0; i < 10; i++) idle();
        chk(nmi == 1, "R8 NMI held until cleared", int'(nmi), 1);
        cyc(0, 0, 16'h0, 0, '0, 1);
        chk(nmi == 0, "R8 NMI cleared", int'(nmi), 0);

        // R4 + R10: later write ignored; tick gating
        cyc(0, 0, 16'h0, 1, mk(0, 1, 0, 1), 0);
        for (int i = 1; i <= 5; i++) begin tk1(); idle(); end
        chk(nmi == 0 && rst_req == 0, "R10 only ticked cycles count", int'(nmi), 0);
        tk1();
        chk(nmi == 1, "R4 second control write ignored", int'(nmi), 1);

        // R8: set wins over clear
        cyc(0, 0, 16'h0, 0, '0, 1);
        for (int i = 1; i <= 5; i++) tk1();
        cyc(1, 0, 16'h0, 0, '0, 1);
        chk(nmi == 1, "R8 timeout beats clear", int'(nmi), 1);

        // R11: service on the final step prevents the timeout
        cyc(0, 0, 16'h0, 0, '0, 1);
        cyc(0, 1, 16'h556C, 0, '0, 0);
        for (int i = 1; i <= 5; i++) tk1();
        cyc(1, 1, 16'hAA39, 0, '0, 0);
        chk(nmi == 0, "R11 service on final step", int'(nmi), 0);
        for (int i = 1; i <= 5; i++) tk1();
        chk(nmi == 0, "R11 reload after late service", int'(nmi), 0);
        tk1();
        chk(nmi == 1, "R11 next timeout after reload", int'(nmi), 1);

        // R9: disabled stays quiet; re-enable attempt ignored (R4)
        do_reset();
        cyc(0, 0, 16'h0, 1, mk(0, 1, 0, 0), 0);
        hi = 0;
        for (int i = 0; i < 300; i++) begin tk1(); if (rst_req || nmi) hi++; end
        chk(hi == 0, "R9 disabled gives no timeout", hi, 0);
        cyc(0, 0, 16'h0, 1, mk(1, 1, 0, 0), 0);
        hi = 0;
        for (int i = 0; i < 100; i++) begin tk1(); if (rst_req || nmi) hi++; end
        chk(hi == 0, "R4 enable after lock ignored", hi, 0);

        // R10: prescaler on, period 2, reset action
        do_reset();
        cyc(0, 0, 16'h0, 1, mk(1, 1, 1, 2), 0);
        rise = -1;
        for (int i = 1; i <= 20; i++) begin
            tk1();
            if (rst_req && rise < 0) rise = i;
        end
        chk(rise == 3 * PRESCALE, "R10 prescaled steps", rise, 3 * PRESCALE);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog for a hung run
    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule